// File: doc/BRIEF.md
# Passive SPI Bus Monitor

This block watches an SPI bus without driving it. The clock, both data lines and the chip-select pin come in as plain asynchronous inputs. They are resynchronized into a faster system clock. The block finds the data-sampling edge of the serial clock from the configured clock polarity and phase. It then shifts the controller-to-peripheral line and the peripheral-to-controller line into two words side by side. Bit order and word length are set at run time.

For every finished word the block raises a one-cycle strobe. The strobe carries:
- both words, each with its own valid flag;
- a warning flag, set when chip select was inactive at the final bit;
- the word duration in system clocks, which software divides into the word length to derive the bus bit rate.

Every chip-select level change gives a separate one-cycle event carrying the old and new levels. The change also discards any partly shifted word.

The control path is a three-state machine:
- **INIT** holds until the synchronizers are full, then issues the startup chip-select event. This is transition *INIT→IDLE*.
- **IDLE** means no bit of a word has arrived yet. A sample edge on a word longer than one bit moves to COLLECT (*IDLE→COLLECT*). A sample edge on a one-bit word completes that word at once and stays in IDLE (*IDLE→IDLE on complete*).
- **COLLECT** takes further bits. It returns to IDLE on the final bit (*COLLECT→IDLE on complete*) or on a chip-select change with no coincident sample edge (*COLLECT→IDLE on abort*). When a chip-select change and a sample edge fall in the same cycle, the old bits are dropped and that bit starts a new word (*COLLECT→COLLECT on restart*).

Top module: `spi_bus_monitor`

## Requirements
- R1: All four bus inputs pass two synchronizing flops. A data bit is taken on the serial clock's rising edge when polarity equals phase (modes 0 and 3), and on its falling edge otherwise (modes 1 and 2).
- R2: With `cfg_lsb_first`=0 the first bit taken lands at bit position length-1 and later bits fill downward. With `cfg_lsb_first`=1 the first bit lands at position 0 and later bits fill upward. Output bits at or above the word length are zero.
- R3: A word completes when the number of bits taken equals `cfg_word_len`, for any length from 1 to MAX_WORD. The value 0 acts as 1. Completion gives exactly one cycle of `word_valid`, and the next bit starts a fresh word.
- R4: A data line whose capture enable is low reports its valid flag as 0 and its data as all zeros. The other line is reported normally.
- R5: While chip select is in use, each change of its synchronized level pulses `cs_event` for one cycle. `cs_old` and `cs_new` carry the levels, coded 2'b00 for low and 2'b01 for high. Bits already taken for the current word are discarded, so no word is reported from them.
- R6: After reset, exactly one `cs_event` is issued with `cs_old`=2'b10 (unknown) and `cs_new` equal to the present level. When `cfg_cs_present` is 0, `cs_new` is 2'b11 (absent) and no further events follow.
- R7: `word_cs_warn` is 1 exactly when chip select was inactive at the final bit of the word. Inactive means high when `cfg_cs_active_high`=0 and low when it is 1. The flag is never set when `cfg_cs_present` is 0.
- R8: `word_duration` counts system clocks from the first bit's sample edge to the last bit's sample edge, both inclusive. A one-bit word therefore reports 1.
- R9: `word_duration` saturates at its all-ones value instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | 0: sample on leading edge, 1: on trailing edge |
| cfg_lsb_first | input | 1 | Bit order: 1 places the first bit at position 0 |
| cfg_word_len | input | $clog2(MAX_WORD+1) | Bits per word, 1..MAX_WORD |
| cfg_mosi_en | input | 1 | Capture enable, controller-to-peripheral line |
| cfg_miso_en | input | 1 | Capture enable, peripheral-to-controller line |
| cfg_cs_active_high | input | 1 | Chip-select polarity, 0 = active low |
| cfg_cs_present | input | 1 | Chip-select pin is wired and watched |
| spi_sclk | input | 1 | Bus serial clock (asynchronous) |
| spi_mosi | input | 1 | Bus controller-to-peripheral data |
| spi_miso | input | 1 | Bus peripheral-to-controller data |
| spi_cs | input | 1 | Bus chip select |
| word_valid | output | 1 | One-cycle strobe for a completed word |
| word_mosi | output | MAX_WORD | Controller-to-peripheral word |
| word_mosi_ok | output | 1 | word_mosi carries captured data |
| word_miso | output | MAX_WORD | Peripheral-to-controller word |
| word_miso_ok | output | 1 | word_miso carries captured data |
| word_cs_warn | output | 1 | Chip select inactive at the final bit |
| word_duration | output | DUR_W | Inclusive word length in system clocks |
| cs_event | output | 1 | One-cycle strobe for a chip-select event |
| cs_old | output | 2 | Previous level: 00 low, 01 high, 10 unknown |
| cs_new | output | 2 | New level: 00 low, 01 high, 11 absent |

## Verification
The bench sweeps all four clock modes, both bit orders and several word lengths, including the one-bit word and the full width. A design with the sampling edge swapped would shift in each bit at the wrong edge and show one-position data skew. A design that reverses bit placement, or leaves stale high bits, shows the wrong word. A one-bit word catches a design that never reaches completion from IDLE.

Directed cases cover the following:
- A chip-select toggle in the middle of a word, which catches a design that keeps the partial bits and reports a corrupted word.
- Words clocked with chip select inactive under both polarities, and with the pin marked absent, which expose a warning tied to the wrong level.
- A disabled data line, which exposes a design that leaks its data.
- A slow word whose true length exceeds the counter, which shows a design that wraps instead of saturating.

Durations are checked against the exact inclusive count, so an off-by-one start point fails.

// File: rtl/spi_mon_pkg.sv
package spi_mon_pkg;

    typedef enum logic [1:0] {
        ST_INIT,
        ST_IDLE,
        ST_COLLECT
    } mon_state_e;

    localparam logic [1:0] CSL_LOW     = 2'b00;
    localparam logic [1:0] CSL_HIGH    = 2'b01;
    localparam logic [1:0] CSL_UNKNOWN = 2'b10;
    localparam logic [1:0] CSL_ABSENT  = 2'b11;

endpackage

// File: rtl/spi_mon_sync.sv
module spi_mon_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/spi_mon_edge.sv
module spi_mon_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_s,
    input  logic cpol,
    input  logic cpha,
    output logic sample_edge
);

    logic sclk_q;
    logic sample_level;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
        end else begin
            sclk_q <= sclk_s;
        end
    end

    // Modes 0 and 3 take data when the clock becomes 1, modes 1 and 2 when it becomes 0.
    assign sample_level = ~(cpol ^ cpha);
    assign sample_edge  = (sclk_s != sclk_q) && (sclk_s == sample_level);

endmodule

// File: rtl/spi_mon_shift.sv
module spi_mon_shift #(
    parameter int MAX_WORD = 16,
    localparam int IDX_W   = (MAX_WORD > 1) ? $clog2(MAX_WORD) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                load,
    input  logic                restart,
    input  logic                flush,
    input  logic                din,
    input  logic [IDX_W-1:0]    pos,
    output logic [MAX_WORD-1:0] merged
);

    logic [MAX_WORD-1:0] data_q;

    always_comb begin
        merged = (restart || !enable) ? '0 : data_q;
        if (enable) begin
            merged[pos] = din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (load) begin
            data_q <= flush ? '0 : merged;
        end else if (flush) begin
            data_q <= '0;
        end
    end

endmodule

// File: rtl/spi_bus_monitor.sv
module spi_bus_monitor
    import spi_mon_pkg::*;
#(
    parameter int MAX_WORD    = 16,
    parameter int DUR_W       = 16,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W      = $clog2(MAX_WORD + 1),
    localparam int IDX_W      = (MAX_WORD > 1) ? $clog2(MAX_WORD) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_cpol,
    input  logic                cfg_cpha,
    input  logic                cfg_lsb_first,
    input  logic [CNT_W-1:0]    cfg_word_len,
    input  logic                cfg_mosi_en,
    input  logic                cfg_miso_en,
    input  logic                cfg_cs_active_high,
    input  logic                cfg_cs_present,
    input  logic                spi_sclk,
    input  logic                spi_mosi,
    input  logic                spi_miso,
    input  logic                spi_cs,
    output logic                word_valid,
    output logic [MAX_WORD-1:0] word_mosi,
    output logic                word_mosi_ok,
    output logic [MAX_WORD-1:0] word_miso,
    output logic                word_miso_ok,
    output logic                word_cs_warn,
    output logic [DUR_W-1:0]    word_duration,
    output logic                cs_event,
    output logic [1:0]          cs_old,
    output logic [1:0]          cs_new
);

    localparam int             LANES     = 2;
    localparam int             INIT_WAIT = SYNC_STAGES + 2;
    localparam int             INIT_W    = $clog2(INIT_WAIT + 1);
    localparam logic [DUR_W-1:0] DUR_MAX = {DUR_W{1'b1}};

    // ---------------- synchronizers and edge finder ----------------
    logic [3:0] pins_s;
    logic       sclk_s, mosi_s, miso_s, cs_s;
    logic       sample_edge;

    spi_mon_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({spi_cs, spi_miso, spi_mosi, spi_sclk}),
        .q     (pins_s)
    );

    assign sclk_s = pins_s[0];
    assign mosi_s = pins_s[1];
    assign miso_s = pins_s[2];
    assign cs_s   = pins_s[3];

    spi_mon_edge u_edge (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_s      (sclk_s),
        .cpol        (cfg_cpol),
        .cpha        (cfg_cpha),
        .sample_edge (sample_edge)
    );

    // ---------------- control state ----------------
    mon_state_e        state_q, state_d;
    logic [INIT_W-1:0] init_cnt_q;
    logic              cs_prev_q;
    logic [CNT_W-1:0]  bit_cnt_q;
    logic [DUR_W-1:0]  dur_q;

    logic [CNT_W-1:0]  len_eff;
    logic              running;
    logic              init_done;
    logic              cs_changed;
    logic              take_bit;
    logic [CNT_W-1:0]  bit_idx;
    logic              first_bit;
    logic              last_bit;
    logic              cs_inactive;
    logic [IDX_W-1:0]  bit_pos;
    logic [DUR_W-1:0]  dur_inc;
    logic [DUR_W-1:0]  dur_word;

    always_comb begin
        if (cfg_word_len == '0) begin
            len_eff = CNT_W'(1);
        end else if (cfg_word_len > CNT_W'(MAX_WORD)) begin
            len_eff = CNT_W'(MAX_WORD);
        end else begin
            len_eff = cfg_word_len;
        end
    end

    assign running     = (state_q != ST_INIT);
    assign init_done   = (state_q == ST_INIT) && (init_cnt_q == INIT_W'(INIT_WAIT));
    assign cs_changed  = running && cfg_cs_present && (cs_s != cs_prev_q);
    assign take_bit    = running && sample_edge;
    assign bit_idx     = cs_changed ? '0 : bit_cnt_q;
    assign first_bit   = (bit_idx == '0);
    assign last_bit    = take_bit && (bit_idx == (len_eff - CNT_W'(1)));
    assign cs_inactive = cfg_cs_present && (cfg_cs_active_high ? ~cs_s : cs_s);
    assign bit_pos     = cfg_lsb_first ? IDX_W'(bit_idx)
                                       : IDX_W'(len_eff - CNT_W'(1) - bit_idx);
    assign dur_inc     = (dur_q == DUR_MAX) ? dur_q : dur_q + DUR_W'(1);
    assign dur_word    = first_bit ? DUR_W'(1) : dur_inc;

    // ---------------- data lanes ----------------
    logic                lane_din [LANES];
    logic                lane_en  [LANES];
    logic [MAX_WORD-1:0] lane_word[LANES];

    assign lane_din[0] = mosi_s;
    assign lane_din[1] = miso_s;
    assign lane_en[0]  = cfg_mosi_en;
    assign lane_en[1]  = cfg_miso_en;

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            spi_mon_shift #(.MAX_WORD(MAX_WORD)) u_shift (
                .clk     (clk),
                .rst_n   (rst_n),
                .enable  (lane_en[g]),
                .load    (take_bit),
                .restart (first_bit),
                .flush   (last_bit || (cs_changed && !take_bit)),
                .din     (lane_din[g]),
                .pos     (bit_pos),
                .merged  (lane_word[g])
            );
        end
    endgenerate

    // ---------------- next-state logic ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_INIT: begin
                if (init_done) begin
                    state_d = ST_IDLE;
                end
            end
            ST_IDLE: begin
                if (take_bit && !last_bit) begin
                    state_d = ST_COLLECT;
                end
            end
            ST_COLLECT: begin
                if (last_bit) begin
                    state_d = ST_IDLE;
                end else if (cs_changed && !take_bit) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_INIT;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_INIT;
            init_cnt_q <= '0;
            cs_prev_q  <= 1'b0;
            bit_cnt_q  <= '0;
            dur_q      <= '0;
        end else begin
            state_q   <= state_d;
            cs_prev_q <= cs_s;
            if (state_q == ST_INIT && !init_done) begin
                init_cnt_q <= init_cnt_q + INIT_W'(1);
            end
            if (take_bit) begin
                bit_cnt_q <= last_bit ? '0 : bit_idx + CNT_W'(1);
            end else if (cs_changed) begin
                bit_cnt_q <= '0;
            end
            if (take_bit && first_bit) begin
                dur_q <= DUR_W'(1);
            end else if (cs_changed) begin
                dur_q <= '0;
            end else if (state_q == ST_COLLECT) begin
                dur_q <= dur_inc;
            end
        end
    end

    // ---------------- output register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_valid    <= 1'b0;
            word_mosi     <= '0;
            word_mosi_ok  <= 1'b0;
            word_miso     <= '0;
            word_miso_ok  <= 1'b0;
            word_cs_warn  <= 1'b0;
            word_duration <= '0;
            cs_event      <= 1'b0;
            cs_old        <= CSL_UNKNOWN;
            cs_new        <= CSL_UNKNOWN;
        end else begin
            word_valid <= last_bit;
            cs_event   <= 1'b0;
            if (last_bit) begin
                word_mosi     <= lane_word[0];
                word_mosi_ok  <= cfg_mosi_en;
                word_miso     <= lane_word[1];
                word_miso_ok  <= cfg_miso_en;
                word_cs_warn  <= cs_inactive;
                word_duration <= dur_word;
            end
            if (init_done) begin
                cs_event <= 1'b1;
                cs_old   <= CSL_UNKNOWN;
                cs_new   <= cfg_cs_present ? {1'b0, cs_s} : CSL_ABSENT;
            end else if (cs_changed) begin
                cs_event <= 1'b1;
                cs_old   <= {1'b0, cs_prev_q};
                cs_new   <= {1'b0, cs_s};
            end
        end
    end

endmodule

// File: rtl/spi_mon_checker.sv
module spi_mon_checker
    import spi_mon_pkg::*;
#(
    parameter int MAX_WORD = 16,
    parameter int DUR_W    = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cfg_cs_present,
    input logic                word_valid,
    input logic [MAX_WORD-1:0] word_mosi,
    input logic                word_mosi_ok,
    input logic [MAX_WORD-1:0] word_miso,
    input logic                word_miso_ok,
    input logic                word_cs_warn,
    input logic [DUR_W-1:0]    word_duration,
    input logic                cs_event,
    input logic [1:0]          cs_old,
    input logic [1:0]          cs_new
);

    logic seen_q;
    logic absent_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q   <= 1'b0;
            absent_q <= 1'b0;
        end else if (cs_event) begin
            seen_q <= 1'b1;
            if (cs_new == CSL_ABSENT) begin
                absent_q <= 1'b1;
            end
        end
    end

    a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);

    a_r4_mosi_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && !word_mosi_ok) |-> (word_mosi == '0));

    a_r4_miso_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && !word_miso_ok) |-> (word_miso == '0));

    a_r8_duration_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> (word_duration != '0));

    a_r6_unknown_only_first: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_event && cs_old == CSL_UNKNOWN) |-> !seen_q);

    a_r6_absent_silent: assert property (@(posedge clk) disable iff (!rst_n)
        cs_event |-> !absent_q);

    a_r5_levels_differ: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_event && cs_old != CSL_UNKNOWN) |-> (cs_old != cs_new && !cs_new[1]));

    a_r7_warn_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && word_cs_warn) |-> cfg_cs_present);

endmodule

bind spi_bus_monitor spi_mon_checker #(.MAX_WORD(MAX_WORD), .DUR_W(DUR_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_cs_present (cfg_cs_present),
    .word_valid     (word_valid),
    .word_mosi      (word_mosi),
    .word_mosi_ok   (word_mosi_ok),
    .word_miso      (word_miso),
    .word_miso_ok   (word_miso_ok),
    .word_cs_warn   (word_cs_warn),
    .word_duration  (word_duration),
    .cs_event       (cs_event),
    .cs_old         (cs_old),
    .cs_new         (cs_new)
);

// File: tb/spi_bus_monitor_tb.sv
module spi_bus_monitor_tb;

    localparam int MAXW  = 16;
    localparam int DUR_W = 6;
    localparam int CNT_W = 5;
    localparam int DMAX  = 63;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic             cfg_cpol = 0, cfg_cpha = 0, cfg_lsb_first = 0;
    logic [CNT_W-1:0] cfg_word_len = 8;
    logic             cfg_mosi_en = 1, cfg_miso_en = 1;
    logic             cfg_cs_active_high = 0, cfg_cs_present = 1;
    logic             spi_sclk = 0, spi_mosi = 0, spi_miso = 0, spi_cs = 1;

    logic             word_valid, word_mosi_ok, word_miso_ok, word_cs_warn, cs_event;
    logic [MAXW-1:0]  word_mosi, word_miso;
    logic [DUR_W-1:0] word_duration;
    logic [1:0]       cs_old, cs_new;

    spi_bus_monitor #(.MAX_WORD(MAXW), .DUR_W(DUR_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_lsb_first(cfg_lsb_first),
        .cfg_word_len(cfg_word_len), .cfg_mosi_en(cfg_mosi_en), .cfg_miso_en(cfg_miso_en),
        .cfg_cs_active_high(cfg_cs_active_high), .cfg_cs_present(cfg_cs_present),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs(spi_cs),
        .word_valid(word_valid), .word_mosi(word_mosi), .word_mosi_ok(word_mosi_ok),
        .word_miso(word_miso), .word_miso_ok(word_miso_ok), .word_cs_warn(word_cs_warn),
        .word_duration(word_duration), .cs_event(cs_event), .cs_old(cs_old), .cs_new(cs_new)
    );

    int n_chk = 0;
    int n_fail = 0;
    int wcnt = 0;
    int ccnt = 0;
    logic [MAXW-1:0]  g_mosi, g_miso;
    logic             g_mok, g_sok, g_warn;
    logic [DUR_W-1:0] g_dur;
    logic [1:0]       g_old, g_new;

    always @(negedge clk) begin
        if (word_valid) begin
            wcnt++;
            g_mosi = word_mosi; g_miso = word_miso;
            g_mok = word_mosi_ok; g_sok = word_miso_ok;
            g_warn = word_cs_warn; g_dur = word_duration;
        end
        if (cs_event) begin
            ccnt++;
            g_old = cs_old; g_new = cs_new;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input bit cpol, input bit cpha, input bit lsb, input int len,
                            input bit m_en, input bit s_en, input bit cs_hi,
                            input bit cs_pres, input bit cs_lvl);
        int c0;
        rst_n = 1'b0;
        cfg_cpol = cpol; cfg_cpha = cpha; cfg_lsb_first = lsb;
        cfg_word_len = CNT_W'(len); cfg_mosi_en = m_en; cfg_miso_en = s_en;
        cfg_cs_active_high = cs_hi; cfg_cs_present = cs_pres;
        spi_sclk = cpol; spi_cs = cs_lvl; spi_mosi = 0; spi_miso = 0;
        wait_clks(3);
        chk(word_valid == 0 && cs_event == 0, "R6 reset outputs idle", int'(word_valid), 0);
        c0 = ccnt;
        rst_n = 1'b1;
        wait_clks(10);
        chk(ccnt == c0 + 1, "R6 one startup event", ccnt - c0, 1);
        chk(g_old == 2'b10, "R6 startup old unknown", int'(g_old), 2);
        chk(g_new == (cs_pres ? {1'b0, cs_lvl} : 2'b11), "R6 startup new level",
            int'(g_new), cs_pres ? int'(cs_lvl) : 3);
    endtask

    // Clock out nbits of a len-bit word, then return the clock to idle.
    task automatic send_bits(input int len, input int nbits, input logic [MAXW-1:0] mv,
                             input logic [MAXW-1:0] sv, input int h);
        logic sl;
        sl = ~(cfg_cpol ^ cfg_cpha);
        for (int i = 0; i < nbits; i++) begin
            int idx;
            idx = cfg_lsb_first ? i : len - 1 - i;
            if (spi_sclk == sl) spi_sclk = ~sl;
            spi_mosi = mv[idx];
            spi_miso = sv[idx];
            wait_clks(h);
            spi_sclk = sl;
            wait_clks(h);
        end
        if (spi_sclk != cfg_cpol) begin
            spi_sclk = cfg_cpol;
        end
        wait_clks(8);
    endtask

    task automatic word_check(input int len, input logic [MAXW-1:0] mv,
                              input logic [MAXW-1:0] sv, input int h, input bit exp_warn);
        int w0, exp_d;
        logic [MAXW-1:0] mask, em, es;
        mask = (len >= MAXW) ? {MAXW{1'b1}} : MAXW'((32'd1 << len) - 1);
        em = cfg_mosi_en ? (mv & mask) : '0;
        es = cfg_miso_en ? (sv & mask) : '0;
        exp_d = (len - 1) * 2 * h + 1;
        if (exp_d > DMAX) exp_d = DMAX;
        w0 = wcnt;
        send_bits(len, len, mv, sv, h);
        chk(wcnt == w0 + 1, "R3 one word per length", wcnt - w0, 1);
        chk(g_mosi == em, "R1 R2 mosi word", int'(g_mosi), int'(em));
        chk(g_miso == es, "R1 R2 miso word", int'(g_miso), int'(es));
        chk(g_mok == cfg_mosi_en && g_sok == cfg_miso_en, "R4 lane valid flags",
            int'({g_mok, g_sok}), int'({cfg_mosi_en, cfg_miso_en}));
        chk(int'(g_dur) == exp_d, "R8 R9 duration", int'(g_dur), exp_d);
        chk(g_warn == exp_warn, "R7 warning flag", int'(g_warn), int'(exp_warn));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int lens[5];
        logic [MAXW-1:0] v;
        int c0, w0;
        lens = '{1, 2, 5, 8, 16};

        // Sweep: modes (R1), bit orders (R2), lengths (R3), exact durations (R8).
        for (int m = 0; m < 4; m++) begin
            for (int b = 0; b < 2; b++) begin
                for (int li = 0; li < 5; li++) begin
                    do_reset(m[1], m[0], b[0], lens[li], 1, 1, 0, 1, 1);
                    c0 = ccnt;
                    spi_cs = 0;
                    wait_clks(8);
                    chk(ccnt == c0 + 1 && g_old == 2'b01 && g_new == 2'b00,
                        "R5 select event", int'({g_old, g_new}), 1);
                    v = MAXW'(16'hA53C ^ (li * 16'h1357) ^ (m * 16'h0F0F) ^ (b * 16'h6006));
                    word_check(lens[li], v, ~v, 2, 0);
                    word_check(lens[li], ~v ^ 16'h5A5A, v ^ 16'h00FF, 2, 0);
                end
            end
        end

        // R3: length 0 acts as a one-bit word.
        do_reset(0, 0, 0, 0, 1, 1, 0, 1, 0);
        word_check(1, 16'h0001, 16'h0000, 2, 0);

        // R5: chip-select toggle mid-word discards the partial bits.
        do_reset(0, 0, 0, 8, 1, 1, 0, 1, 0);
        w0 = wcnt;
        send_bits(8, 3, 16'hFF, 16'hFF, 2);
        c0 = ccnt;
        spi_cs = 1;
        wait_clks(8);
        chk(ccnt == c0 + 1 && g_old == 2'b00 && g_new == 2'b01, "R5 deselect event",
            int'({g_old, g_new}), 1);
        spi_cs = 0;
        wait_clks(8);
        chk(ccnt == c0 + 2 && g_old == 2'b01 && g_new == 2'b00, "R5 reselect event",
            int'({g_old, g_new}), 1);
        chk(wcnt == w0, "R5 no word from partial bits", wcnt - w0, 0);
        word_check(8, 16'h0012, 16'h00C3, 2, 0);

        // R7: word clocked while chip select inactive, active-low polarity.
        do_reset(1, 1, 0, 8, 1, 1, 0, 1, 1);
        word_check(8, 16'h0081, 16'h007E, 2, 1);

        // R7: active-high polarity, low level is inactive.
        do_reset(0, 1, 1, 5, 1, 1, 1, 1, 0);
        word_check(5, 16'h0015, 16'h000A, 2, 1);
        spi_cs = 1;
        wait_clks(8);
        word_check(5, 16'h0003, 16'h001C, 2, 0);

        // R6, R7: chip select absent, no events, no warning.
        do_reset(0, 0, 0, 8, 1, 1, 0, 0, 1);
        c0 = ccnt;
        spi_cs = 0;
        wait_clks(8);
        spi_cs = 1;
        wait_clks(8);
        chk(ccnt == c0, "R6 absent pin gives no events", ccnt - c0, 0);
        word_check(8, 16'h00A7, 16'h0031, 2, 0);

        // R4: one lane disabled at a time.
        do_reset(0, 0, 0, 8, 0, 1, 0, 1, 0);
        word_check(8, 16'h00FF, 16'h0096, 2, 0);
        do_reset(1, 0, 1, 8, 1, 0, 0, 1, 0);
        word_check(8, 16'h0069, 16'h00FF, 2, 0);

        // R9: slow word whose real length 91 exceeds 63.
        do_reset(0, 0, 0, 16, 1, 1, 0, 1, 0);
        word_check(16, 16'hBEEF, 16'h1234, 3, 0);
        word_check(16, 16'h0F0F, 16'hF00F, 2, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule